// File: doc/BRIEF.md
# Three-Wire Serial Latch Port

This block is the control port of a frequency synthesizer. An external controller drives three wires: a serial clock, a serial data line and a load strobe. The port samples all three with its own system clock. On each rising serial-clock edge it shifts one data bit into a 21-bit register, most-significant bit first. When the load strobe rises, the upper 19 bits of that register are copied into one of four holding slots. The two bits shifted in last pick the slot. The address bits themselves are not stored. The four slots drive the synthesizer in parallel.

A data-out line gives the register's top bit. It changes on the falling serial-clock edge, half a serial period after the shift, so that a second port can be chained behind this one. A small state machine orders the work. ST_SHIFT is the idle-and-shifting state. It moves to ST_COMMIT when the load strobe rises. ST_COMMIT lasts one cycle and writes the selected slot. From there the machine goes to ST_HOLD if the strobe is still high, or back to ST_SHIFT if it is already low. ST_HOLD returns to ST_SHIFT when the strobe falls. Serial-clock edges are ignored outside ST_SHIFT.

Top module: `serial_latch_port`

## Requirements
- R1: After reset all four slots read zero and `ser_dout` is 0.
- R2: While the load strobe is low, each rising serial-clock edge shifts `ser_data` into bit 0 of the 21-bit register. Earlier bits move toward bit 20, so bit 20 holds the first bit sent and bits 1:0 hold the last two bits sent.
- R3: A rising load strobe writes register bits 20:2 into slot k, where k is the value of register bits 1:0. Slot k appears on `slot_words[k*19 +: 19]`.
- R4: A write changes only the selected slot. The other three slots keep their contents.
- R5: Serial-clock edges that occur while the load strobe is high do not shift the register. Such edges change neither `ser_dout` nor what a later load writes.
- R6: `ser_dout` takes register bit 20 on each falling serial-clock edge. It holds that value from one falling edge to the next, including across the rising edge in between.
- R7: Shifting in new words without a load leaves all slots unchanged.
- R8: A later write to a slot fully replaces that slot's earlier contents, including with an all-zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It must run at least a few times faster than the serial clock. |
| rst_n | input | 1 | Active-low reset. It clears the register, the slots and the data-out line. |
| ser_clk | input | 1 | Serial clock. Asynchronous; it is synchronized inside the block. |
| ser_data | input | 1 | Serial data, sent MSB first. |
| ser_le | input | 1 | Load strobe. A rising edge commits the word; while it is high, shifting stops. |
| ser_dout | output | 1 | Register MSB. It updates on the falling serial-clock edge. |
| slot_words | output | 76 | The four 19-bit slots, concatenated with slot 0 in the low bits. |

## Verification
A wrong shift order, or a wrong split between payload and address, shows up on the first load. The payload lands in the wrong slot, or in the right slot with the wrong bits, and this is visible a few system clocks after the strobe rises. If the state machine stayed in ST_SHIFT while the strobe was high, shifting that should be blocked would change the address bits. A reload with no new serial bits would then write a different slot, and the bench compares all four slots against its own model after every load. A data-out line that updated on the wrong edge shows up within one half of a serial period: the bench samples it between the rising and falling edges.

// File: rtl/ser_latch_pkg.sv
package ser_latch_pkg;

    // Control states of the serial port
    typedef enum logic [1:0] {
        ST_SHIFT  = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } port_state_e;

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
    import ser_latch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_s,
    input  logic        le_s,
    output logic        shift_en,
    output logic        echo_en,
    output logic        wr_en,
    output port_state_e state
);

    port_state_e state_nx;
    logic        sclk_q;
    logic        le_q;
    logic        sclk_rise;
    logic        sclk_fall;
    logic        le_rise;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign le_rise   = le_s & ~le_q;

    // State register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_SHIFT;
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            state  <= state_nx;
            sclk_q <= sclk_s;
            le_q   <= le_s;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx = state;
        shift_en = 1'b0;
        wr_en    = 1'b0;
        echo_en  = sclk_fall;
        unique case (state)
            ST_SHIFT: begin
                shift_en = sclk_rise & ~le_s;
                if (le_rise) state_nx = ST_COMMIT;
            end
            ST_COMMIT: begin
                wr_en    = 1'b1;
                state_nx = le_s ? ST_HOLD : ST_SHIFT;
            end
            ST_HOLD: begin
                if (!le_s) state_nx = ST_SHIFT;
            end
            default: state_nx = ST_SHIFT;
        endcase
    end

    // R3: a commit lasts exactly one cycle
    a_r3_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (state != ST_COMMIT));

    // R3: a load edge seen while shifting leads to a commit
    a_r3_load_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && le_rise) |=> (state == ST_COMMIT));

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             echo_en,
    input  logic             din,
    output logic [WIDTH-1:0] sreg,
    output logic             dout
);

    localparam int MSB = WIDTH - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (shift_en) begin
            sreg <= {sreg[MSB-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (echo_en) begin
            dout <= sreg[MSB];
        end
    end

    // R2: the new bit enters at the bottom
    a_r2_enter_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sreg[0] == $past(din)));

    // R6: data out moves only on a falling serial edge
    a_r6_echo_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !echo_en |=> $stable(dout));

endmodule

// File: rtl/latch_bank.sv
module latch_bank #(
    parameter int SLOTS = 4,
    parameter int DW    = 19,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [SLOTS*DW-1:0] slots_flat
);

    logic [DW-1:0] mem [SLOTS];

    genvar k;
    generate
        for (k = 0; k < SLOTS; k++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[k] <= '0;
                end else if (wr_en && (wr_idx == IW'(k))) begin
                    mem[k] <= wr_data;
                end
            end

            assign slots_flat[k*DW +: DW] = mem[k];

            // R4: unselected slots do not move
            a_r4_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_en || wr_idx != IW'(k)) |=> $stable(mem[k]));
        end
    endgenerate

    // R3: the addressed slot receives the payload
    a_r3_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/serial_latch_port.sv
module serial_latch_port
    import ser_latch_pkg::*;
#(
    parameter int WORD_W      = 21,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SLOTS      = 1 << ADDR_W,
    localparam int PAY_W      = WORD_W - ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk,
    input  logic                   ser_data,
    input  logic                   ser_le,
    output logic                   ser_dout,
    output logic [SLOTS*PAY_W-1:0] slot_words
);

    logic [2:0]        pins_s;
    logic              shift_en;
    logic              echo_en;
    logic              wr_en;
    port_state_e       ctl_state;
    logic [WORD_W-1:0] sreg;

    sig_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_le, ser_data, ser_clk}),
        .d_sync  (pins_s)
    );

    port_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[0]),
        .le_s     (pins_s[2]),
        .shift_en (shift_en),
        .echo_en  (echo_en),
        .wr_en    (wr_en),
        .state    (ctl_state)
    );

    shift_chain #(
        .WIDTH (WORD_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .echo_en  (echo_en),
        .din      (pins_s[1]),
        .sreg     (sreg),
        .dout     (ser_dout)
    );

    latch_bank #(
        .SLOTS (SLOTS),
        .DW    (PAY_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (sreg[ADDR_W-1:0]),
        .wr_data    (sreg[WORD_W-1:ADDR_W]),
        .slots_flat (slot_words)
    );

    // R5: the register is frozen whenever the controller is not shifting
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state != ST_SHIFT) |=> $stable(sreg));

    // R7: slots move only in the cycle after a commit
    a_r7_slots_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state != ST_COMMIT) |=> $stable(slot_words));

endmodule

// File: tb/test_serial_latch_port.sv
module test_serial_latch_port;

    localparam int W  = 21;
    localparam int PW = 19;
    localparam int NV = 8;

    // Stimulus words; bits 1:0 are the slot index
    localparam logic [W-1:0] VEC [NV] = '{
        21'h1ABCD5, 21'h0F0F0C, 21'h155557, 21'h0AAAAA,
        21'h1FFFFF, 21'h000001, 21'h123456, 21'h000004
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;
    logic ser_dout;
    logic [4*PW-1:0] slot_words;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [PW-1:0] model [4];

    always #4 clk = ~clk;

    serial_latch_port i_serial_latch_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_le     (ser_le),
        .ser_dout   (ser_dout),
        .slot_words (slot_words)
    );

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        waitn(3);
        ser_clk = 1'b1;
        waitn(5);
        ser_clk = 1'b0;
        waitn(5);
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_load();
        waitn(3);
        ser_le = 1'b1;
        waitn(6);
        ser_le = 1'b0;
        waitn(5);
    endtask

    task automatic chk_slots(input string req);
        for (int k = 0; k < 4; k++)
            chk(req, 32'(slot_words[k*PW +: PW]), 32'(model[k]));
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) model[k] = '0;
        waitn(3);
        // R1: reset state
        chk_slots("R1 reset slots");
        chk("R1 reset dout", 32'(ser_dout), 32'd0);
        rst_n = 1'b1;
        waitn(3);

        // Table walk: R2 order, R3 target, R4 others, R7 no change before load
        for (int v = 0; v < NV; v++) begin
            shift_word(VEC[v]);
            chk_slots("R7 hold while shifting");
            chk("R6 dout msb", 32'(ser_dout), 32'(VEC[v][W-1]));
            pulse_load();
            model[VEC[v][1:0]] = VEC[v][W-1:2];
            chk(v >= 4 ? "R8 overwrite" : "R2 R3 written slot",
                32'(slot_words[VEC[v][1:0]*PW +: PW]), 32'(VEC[v][W-1:2]));
            chk_slots("R4 other slots");
        end

        // R6: data out holds across a rising edge, moves on the falling edge
        shift_word(21'h0ABCD9);
        chk("R6 dout after word", 32'(ser_dout), 32'd0);
        ser_data = 1'b1;
        waitn(3);
        ser_clk = 1'b1;
        waitn(5);
        chk("R6 dout held after rise", 32'(ser_dout), 32'd0);
        ser_clk = 1'b0;
        waitn(5);
        chk("R6 dout after fall", 32'(ser_dout), 32'd1);

        // R5: edges while load is high are ignored
        shift_word(21'h1C3A55);   // slot 1
        pulse_load();
        model[1] = 21'h1C3A55 >> 2;
        chk_slots("R5 setup");
        waitn(3);
        ser_le = 1'b1;
        waitn(6);
        for (int i = 0; i < 5; i++) begin
            ser_data = 1'b0;
            waitn(3);
            ser_clk = 1'b1;
            waitn(5);
            ser_clk = 1'b0;
            waitn(5);
        end
        chk("R5 dout unchanged", 32'(ser_dout), 32'd1);
        ser_le = 1'b0;
        waitn(5);
        pulse_load();
        chk_slots("R5 reload same slot");
        chk("R5 dout after reload", 32'(ser_dout), 32'd1);

        // R1: reset in mid-operation clears everything
        rst_n = 1'b0;
        waitn(2);
        for (int k = 0; k < 4; k++) model[k] = '0;
        chk_slots("R1 second reset");
        chk("R1 second reset dout", 32'(ser_dout), 32'd0);
        rst_n = 1'b1;
        waitn(3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule